// File: doc/BRIEF.md
# Two-Way Data Cache Tag Lookup with Diagnostic Controls

This block holds the tag state of a two-way set-associative data cache: a tag, valid bit, dirty bit, tag parity bit and per-byte check bits for every line of both ways. A requester presents one operation per cycle: load, store or fill. One cycle later the block answers with hit, way and dirty status. A fill places a new line in a victim way. It writes the tag, the parity and the check bits computed from the fill data. A store that hits marks the line dirty and refreshes its check bits. The data array itself lives outside the block. On a load the requester also presents the data read from that array, so that the stored check bits can be compared against it.

A write-only diagnostic control word can switch either way off and force every lookup to hit. It can also turn on tag parity checking and data check-bit checking, and it can inject errors: inverted tag parity on fills, or check bits left stale on fills and stores. The first detected error is latched in a read/write-one-to-clear status register. The register records which kind of error occurred and in which way.

Top module: `dcache_tag_unit`

## Requirements
- R1: After reset both ways are enabled, every diagnostic control is off, every line is invalid and clean, the status register reads 0, the victim pointer points at way 0 and no response is valid.
- R2: A control write takes bits [1:0] as the enables for way 1 and way 0, bit 2 as force-hit, bit 4 as bad-tag-parity injection, bit 5 as stale-check-bit injection, bit 6 as tag parity check enable and bit 7 as data check enable, and acts from the next cycle. A write whose bits [1:0] are both 0 is ignored entirely, and a disabled way never hits.
- R3: Operation codes are 0 for load, 1 for store, 2 for fill and 3 for no operation. A load or store gets its response in the following cycle: valid=1 and hit=1 when an enabled, valid way holds the request tag, with way 0 taking priority. On a hit, way and dirty report the hitting way and the line's dirty bit held before the operation. On a miss, hit, way and dirty are 0.
- R4: A store that hits sets the line dirty. The response raises resp_ext_o exactly when that line was clean before the store, which signals that external activity is needed.
- R5: When force-hit is set, exactly one way is enabled and tag parity checking is off, every load and store hits in the enabled way whatever its tag or valid bit. Dirty still comes from the stored bit. In any other combination force-hit has no effect.
- R6: A fill overwrites the victim line with the request tag and marks it valid and clean. The victim is the lowest enabled invalid way. If every enabled way is valid and both ways are enabled, a pointer that flips on each such fill picks the victim. If only one way is enabled, that way is the victim. The fill response has valid=1, hit=0, and way set to the victim.
- R7: Tag parity is even over tag, valid and dirty. It is inverted on fills while bad-tag-parity injection is on, and a store keeps any existing parity error. With checking enabled, a load or store finding a parity error in an enabled valid way records status bit 0, with status bit 2 set to the lowest such way.
- R8: Check bit k is the XOR of data byte k. With data checking enabled, a load hit whose presented data disagrees with the hit way's stored check bits records status bit 1, with bit 2 set to the hit way. A simultaneous tag parity error keeps priority for bit 2.
- R9: While stale-check-bit injection is on, fills and stores leave the stored check bits unchanged, so later loads are checked against the old bits.
- R10: Status flags are sticky. While any flag is set, new errors are not recorded. Writing 1 to bit 0 or bit 1 clears that flag. Bit 2 reads 0 whenever both flags are clear. A clear and a new error in the same cycle leave the new error recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_op_i | input | 2 | 0 load, 1 store, 2 fill, 3 none |
| req_index_i | input | IDX_W | Set index |
| req_tag_i | input | TAG_W | Address tag |
| req_data_i | input | DATA_W | Fill/store data, or data read from the array on a load |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 8 | Control word |
| stat_we_i | input | 1 | Status write strobe |
| stat_clr_i | input | 2 | Write-one-to-clear for status bits 1:0 |
| stat_o | output | 3 | Status: bit0 tag parity error, bit1 data error, bit2 way |
| resp_valid_o | output | 1 | Response valid |
| resp_hit_o | output | 1 | Lookup hit |
| resp_way_o | output | 1 | Hit way or fill victim |
| resp_dirty_o | output | 1 | Dirty bit of the hit line before the operation |
| resp_ext_o | output | 1 | Store hit to a clean line |

## Verification
The hardest states to reach are the injected errors. Each one only becomes visible after several control reconfigurations that bracket an ordinary operation. For a stale check-bit mismatch, the stimulus fills a line with checking on, turns on stale-bit injection, stores data whose byte parity differs, and turns injection off again. Only the load that follows can then show the error. A tag parity error takes a fill with inversion on, and is seen only once checking is enabled for a later lookup. Round-robin eviction needs both ways of a set already valid. A long random phase then mixes control words, including illegal and ignored ones, with operations over a few sets and tags, while a behavioural model tracks every line.

// File: rtl/dct_pkg.sv
package dct_pkg;
  localparam int NUM_WAYS = 2;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_FILL  = 2'd2,
    OP_NONE  = 2'd3
  } op_e;

  typedef struct packed {
    logic       derr_en;
    logic       tpar_en;
    logic       bad_dchk;
    logic       bad_tpar;
    logic       force_hit;
    logic [1:0] way_en;
  } ctrl_t;
endpackage

// File: rtl/dct_ctrl_reg.sv
module dct_ctrl_reg
  import dct_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output ctrl_t      ctrl_o
);
  ctrl_t ctrl_q;
  logic  unused_rsvd;

  assign unused_rsvd = wdata_i[3];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '{derr_en: 1'b0, tpar_en: 1'b0, bad_dchk: 1'b0, bad_tpar: 1'b0,
                  force_hit: 1'b0, way_en: 2'b11};
    end else if (we_i && (wdata_i[1:0] != 2'b00)) begin
      ctrl_q <= '{derr_en: wdata_i[7], tpar_en: wdata_i[6], bad_dchk: wdata_i[5],
                  bad_tpar: wdata_i[4], force_hit: wdata_i[2], way_en: wdata_i[1:0]};
    end
  end

  assign ctrl_o = ctrl_q;

  p_zero_enable_ignored_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wdata_i[1:0] == 2'b00) |=> $stable(ctrl_q));
endmodule

// File: rtl/dct_way.sv
module dct_way #(
  parameter int SETS  = 16,
  parameter int TAG_W = 20,
  parameter int NB    = 8,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             fill_i,
  input  logic             store_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic             fill_par_i,
  input  logic             chk_we_i,
  input  logic [NB-1:0]    chk_i,
  output logic [TAG_W-1:0] tag_o,
  output logic             valid_o,
  output logic             dirty_o,
  output logic             par_o,
  output logic [NB-1:0]    chk_o
);
  logic [TAG_W-1:0] tag_q [SETS];
  logic [NB-1:0]    chk_q [SETS];
  logic [SETS-1:0]  valid_q, dirty_q, par_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
      par_q   <= '0;
      for (int s = 0; s < SETS; s++) begin
        tag_q[s] <= '0;
        chk_q[s] <= '0;
      end
    end else if (fill_i) begin
      tag_q[idx_i]   <= tag_i;
      valid_q[idx_i] <= 1'b1;
      dirty_q[idx_i] <= 1'b0;
      par_q[idx_i]   <= fill_par_i;
      if (chk_we_i) chk_q[idx_i] <= chk_i;
    end else if (store_i) begin
      dirty_q[idx_i] <= 1'b1;
      // flip parity only if dirty changes, so an injected error survives
      par_q[idx_i]   <= par_q[idx_i] ^ ~dirty_q[idx_i];
      if (chk_we_i) chk_q[idx_i] <= chk_i;
    end
  end

  assign tag_o   = tag_q[idx_i];
  assign valid_o = valid_q[idx_i];
  assign dirty_o = dirty_q[idx_i];
  assign par_o   = par_q[idx_i];
  assign chk_o   = chk_q[idx_i];

  p_fill_valid_clean_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i |=> (valid_q[$past(idx_i)] && !dirty_q[$past(idx_i)]));
  p_store_dirty_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store_i && !fill_i) |=> dirty_q[$past(idx_i)]);
endmodule

// File: rtl/dct_victim.sv
module dct_victim (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] way_en_i,
  input  logic [1:0] valid_i,
  input  logic       fill_i,
  output logic       victim_o
);
  logic       rr_q;
  logic       use_rr;
  logic [1:0] free;

  assign free = way_en_i & ~valid_i;

  always_comb begin
    use_rr = 1'b0;
    if (free[0])               victim_o = 1'b0;
    else if (free[1])          victim_o = 1'b1;
    else if (&way_en_i) begin
      victim_o = rr_q;
      use_rr   = 1'b1;
    end else                   victim_o = way_en_i[1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              rr_q <= 1'b0;
    else if (fill_i && use_rr) rr_q <= ~rr_q;
  end

  p_victim_enabled_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i |-> (victim_o ? way_en_i[1] : way_en_i[0]));
endmodule

// File: rtl/dct_status.sv
module dct_status (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [1:0] clr_i,
  input  logic       tperr_i,
  input  logic       derr_i,
  input  logic       tperr_way_i,
  input  logic       hit_way_i,
  output logic [2:0] stat_o
);
  logic [1:0] flags_q, flags_d;
  logic       way_q, way_d;

  always_comb begin
    flags_d = flags_q & ~(we_i ? clr_i : 2'b00);
    way_d   = way_q;
    if (flags_d == 2'b00) begin
      way_d = 1'b0;
      if (tperr_i || derr_i) begin
        flags_d = {derr_i, tperr_i};
        way_d   = tperr_i ? tperr_way_i : hit_way_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      way_q   <= 1'b0;
    end else begin
      flags_q <= flags_d;
      way_q   <= way_d;
    end
  end

  assign stat_o = {way_q, flags_q};

  p_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|flags_q) && !(we_i && |(clr_i & flags_q))) |=> $stable(stat_o));
  p_capture_tag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_q == 2'b00 && tperr_i) |=> stat_o[0]);
endmodule

// File: rtl/dcache_tag_unit.sv
module dcache_tag_unit
  import dct_pkg::*;
#(
  parameter int SETS  = 16,
  parameter int TAG_W = 20,
  parameter int NB    = 8,
  localparam int IDX_W  = $clog2(SETS),
  localparam int DATA_W = 8 * NB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_op_i,
  input  logic [IDX_W-1:0]  req_index_i,
  input  logic [TAG_W-1:0]  req_tag_i,
  input  logic [DATA_W-1:0] req_data_i,
  input  logic              ctrl_we_i,
  input  logic [7:0]        ctrl_wdata_i,
  input  logic              stat_we_i,
  input  logic [1:0]        stat_clr_i,
  output logic [2:0]        stat_o,
  output logic              resp_valid_o,
  output logic              resp_hit_o,
  output logic              resp_way_o,
  output logic              resp_dirty_o,
  output logic              resp_ext_o
);
  ctrl_t ctrl;
  op_e   op;

  logic [TAG_W-1:0] w_tag [NUM_WAYS];
  logic [NB-1:0]    w_chk [NUM_WAYS];
  logic [NUM_WAYS-1:0] w_valid, w_dirty, w_par, match, pbad, fill_w, store_w;

  logic is_load, is_store, is_fill, is_lookup;
  logic fh_act, hit, hit_way, victim, fill_par, tperr, tperr_way, derr;
  logic [NB-1:0] data_chk;

  function automatic logic [NB-1:0] byte_par(input logic [DATA_W-1:0] d);
    logic [NB-1:0] p;
    for (int b = 0; b < NB; b++) p[b] = ^d[8*b +: 8];
    return p;
  endfunction

  assign op        = op_e'(req_op_i);
  assign is_load   = req_valid_i && (op == OP_LOAD);
  assign is_store  = req_valid_i && (op == OP_STORE);
  assign is_fill   = req_valid_i && (op == OP_FILL);
  assign is_lookup = is_load || is_store;
  assign data_chk  = byte_par(req_data_i);
  assign fill_par  = ~(^req_tag_i) ^ ctrl.bad_tpar;

  dct_ctrl_reg u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ctrl_we_i),
    .wdata_i (ctrl_wdata_i),
    .ctrl_o  (ctrl)
  );

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    assign match[w]   = ctrl.way_en[w] && w_valid[w] && (w_tag[w] == req_tag_i);
    assign pbad[w]    = ctrl.tpar_en && ctrl.way_en[w] && w_valid[w] &&
                        (w_par[w] ^ (^{w_tag[w], w_valid[w], w_dirty[w]}));
    assign fill_w[w]  = is_fill && (victim == w);
    assign store_w[w] = is_store && hit && (hit_way == w);

    dct_way #(.SETS(SETS), .TAG_W(TAG_W), .NB(NB)) u_way (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .idx_i      (req_index_i),
      .fill_i     (fill_w[w]),
      .store_i    (store_w[w]),
      .tag_i      (req_tag_i),
      .fill_par_i (fill_par),
      .chk_we_i   (!ctrl.bad_dchk),
      .chk_i      (data_chk),
      .tag_o      (w_tag[w]),
      .valid_o    (w_valid[w]),
      .dirty_o    (w_dirty[w]),
      .par_o      (w_par[w]),
      .chk_o      (w_chk[w])
    );
  end

  assign fh_act  = ctrl.force_hit && ($countones(ctrl.way_en) == 1) && !ctrl.tpar_en;
  assign hit     = fh_act || (|match);
  assign hit_way = fh_act ? ctrl.way_en[1] : (!match[0] && match[1]);

  assign tperr     = is_lookup && (|pbad);
  assign tperr_way = !pbad[0];
  assign derr      = is_load && hit && ctrl.derr_en && (w_chk[hit_way] != data_chk);

  dct_victim u_victim (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .way_en_i (ctrl.way_en),
    .valid_i  (w_valid),
    .fill_i   (is_fill),
    .victim_o (victim)
  );

  dct_status u_status (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (stat_we_i),
    .clr_i       (stat_clr_i),
    .tperr_i     (tperr),
    .derr_i      (derr),
    .tperr_way_i (tperr_way),
    .hit_way_i   (hit_way),
    .stat_o      (stat_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o <= 1'b0;
      resp_hit_o   <= 1'b0;
      resp_way_o   <= 1'b0;
      resp_dirty_o <= 1'b0;
      resp_ext_o   <= 1'b0;
    end else begin
      resp_valid_o <= req_valid_i && (op != OP_NONE);
      resp_hit_o   <= is_lookup && hit;
      resp_way_o   <= is_fill ? victim : (is_lookup && hit && hit_way);
      resp_dirty_o <= is_lookup && hit && w_dirty[hit_way];
      resp_ext_o   <= is_store && hit && !w_dirty[hit_way];
    end
  end

  p_hit_enabled_way_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_lookup && hit) |=> (resp_way_o ? $past(ctrl.way_en[1]) : $past(ctrl.way_en[0])));
  p_ext_clean_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_ext_o |-> (resp_hit_o && !resp_dirty_o));
  p_fill_free_way0_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_fill && ctrl.way_en[0] && !w_valid[0]) |=> (resp_way_o == 1'b0 && !resp_hit_o));
endmodule

// File: tb/tb_dcache_tag_unit.sv
`timescale 1ns/1ps
module tb_dcache_tag_unit;
  localparam int SETS = 16;
  localparam int TW   = 20;
  localparam int NB   = 8;
  localparam int DW   = 8 * NB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          req_valid = 1'b0;
  logic [1:0]    req_op = 2'd3;
  logic [3:0]    req_index = '0;
  logic [TW-1:0] req_tag = '0;
  logic [DW-1:0] req_data = '0;
  logic          ctrl_we = 1'b0;
  logic [7:0]    ctrl_wdata = '0;
  logic          stat_we = 1'b0;
  logic [1:0]    stat_clr = '0;
  logic [2:0]    stat;
  logic          r_valid, r_hit, r_way, r_dirty, r_ext;

  dcache_tag_unit #(.SETS(SETS), .TAG_W(TW), .NB(NB)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_op_i(req_op),
    .req_index_i(req_index), .req_tag_i(req_tag), .req_data_i(req_data),
    .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wdata), .stat_we_i(stat_we),
    .stat_clr_i(stat_clr), .stat_o(stat), .resp_valid_o(r_valid),
    .resp_hit_o(r_hit), .resp_way_o(r_way), .resp_dirty_o(r_dirty), .resp_ext_o(r_ext)
  );

  // reference model state
  logic [TW-1:0] m_tag [2][SETS];
  logic [NB-1:0] m_chk [2][SETS];
  bit m_v [2][SETS];
  bit m_d [2][SETS];
  bit m_p [2][SETS];
  bit [1:0] m_en;
  bit m_fh, m_btp, m_bdc, m_tpe, m_dee, m_rr;
  bit [1:0] m_flags;
  bit m_sway;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  function automatic logic [NB-1:0] bpar(input logic [DW-1:0] d);
    logic [NB-1:0] p;
    for (int b = 0; b < NB; b++) p[b] = ^d[8*b +: 8];
    return p;
  endfunction

  task automatic model_reset();
    for (int w = 0; w < 2; w++)
      for (int s = 0; s < SETS; s++) begin
        m_tag[w][s] = '0; m_chk[w][s] = '0;
        m_v[w][s] = 0; m_d[w][s] = 0; m_p[w][s] = 0;
      end
    m_en = 2'b11; m_fh = 0; m_btp = 0; m_bdc = 0; m_tpe = 0; m_dee = 0; m_rr = 0;
    m_flags = 0; m_sway = 0;
  endtask

  task automatic step(input string rq, input bit v, input logic [1:0] op, input int idx,
                      input logic [TW-1:0] tg, input logic [DW-1:0] d,
                      input bit cwe, input logic [7:0] cw, input bit swe, input logic [1:0] sclr);
    bit lookup, fill, ld, st, fh, tperr, derr, vict, e_hit, e_way, e_dirty, e_ext;
    int hw, tw;
    logic [7:0] exp_v, act_v;
    req_valid = v; req_op = op; req_index = idx[3:0]; req_tag = tg; req_data = d;
    ctrl_we = cwe; ctrl_wdata = cw; stat_we = swe; stat_clr = sclr;

    ld = v && op == 2'd0; st = v && op == 2'd1; fill = v && op == 2'd2;
    lookup = ld || st;
    fh = m_fh && (m_en == 2'b01 || m_en == 2'b10) && !m_tpe;
    hw = -1;
    if (lookup) begin
      if (fh) hw = (m_en == 2'b10) ? 1 : 0;
      else
        for (int w = 0; w < 2; w++)
          if (hw < 0 && m_en[w] && m_v[w][idx] && m_tag[w][idx] == tg) hw = w;
    end
    tperr = 0; tw = 0;
    if (lookup && m_tpe)
      for (int w = 1; w >= 0; w--)
        if (m_en[w] && m_v[w][idx] &&
            (m_p[w][idx] != ((^m_tag[w][idx]) ^ m_v[w][idx] ^ m_d[w][idx]))) begin
          tperr = 1; tw = w;
        end
    derr = ld && hw >= 0 && m_dee && (m_chk[hw][idx] != bpar(d));
    vict = 0;
    if (fill) begin
      if (m_en[0] && !m_v[0][idx]) vict = 0;
      else if (m_en[1] && !m_v[1][idx]) vict = 1;
      else if (m_en == 2'b11) begin vict = m_rr; m_rr = !m_rr; end
      else vict = (m_en == 2'b10);
    end
    e_hit = hw >= 0;
    e_way = fill ? vict : (e_hit ? hw[0] : 1'b0);
    e_dirty = e_hit ? m_d[hw][idx] : 1'b0;
    e_ext = st && e_hit && !m_d[hw][idx];

    if (fill) begin
      m_tag[vict][idx] = tg; m_v[vict][idx] = 1; m_d[vict][idx] = 0;
      m_p[vict][idx] = (^tg) ^ 1'b1 ^ m_btp;
      if (!m_bdc) m_chk[vict][idx] = bpar(d);
    end else if (st && e_hit) begin
      if (!m_d[hw][idx]) m_p[hw][idx] = !m_p[hw][idx];
      m_d[hw][idx] = 1;
      if (!m_bdc) m_chk[hw][idx] = bpar(d);
    end
    if (swe) m_flags = m_flags & ~sclr;
    if (m_flags == 0) begin
      m_sway = 0;
      if (tperr || derr) begin
        m_flags = {derr, tperr};
        m_sway = tperr ? tw[0] : hw[0];
      end
    end
    if (cwe && cw[1:0] != 0) begin
      m_en = cw[1:0]; m_fh = cw[2]; m_btp = cw[4]; m_bdc = cw[5]; m_tpe = cw[6]; m_dee = cw[7];
    end

    @(posedge clk);
    @(negedge clk);
    exp_v = {v && op != 2'd3, e_hit, e_way, e_dirty, e_ext, m_sway, m_flags};
    act_v = {r_valid, r_hit, r_way, r_dirty, r_ext, stat};
    vectors++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s: {valid,hit,way,dirty,ext,stat} actual %b expected %b", rq, act_v, exp_v);
    end
  endtask

  task automatic op_s(input string rq, input logic [1:0] op, input int idx,
                      input logic [TW-1:0] tg, input logic [DW-1:0] d);
    step(rq, 1'b1, op, idx, tg, d, 1'b0, 8'h00, 1'b0, 2'b00);
  endtask

  task automatic ctrl_s(input string rq, input logic [7:0] cw);
    step(rq, 1'b0, 2'd3, 0, '0, '0, 1'b1, cw, 1'b0, 2'b00);
  endtask

  task automatic clr_s(input string rq, input logic [1:0] c);
    step(rq, 1'b0, 2'd3, 0, '0, '0, 1'b0, 8'h00, 1'b1, c);
  endtask

  localparam logic [DW-1:0] DX = 64'h0123_4567_89AB_CDEF;
  localparam logic [DW-1:0] DY = 64'h0123_4567_89AB_CDEE;

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    step("R1", 1'b0, 2'd3, 0, '0, '0, 1'b0, 8'h00, 1'b0, 2'b00);
    op_s("R1", 2'd0, 3, 20'hAAAAA, DX);
    op_s("R6", 2'd2, 3, 20'hAAAAA, DX);
    op_s("R6", 2'd2, 3, 20'hBBBBB, DY);
    op_s("R3", 2'd0, 3, 20'hAAAAA, DX);
    op_s("R3", 2'd0, 3, 20'hBBBBB, DY);
    op_s("R3", 2'd3, 3, 20'hBBBBB, DY);
    op_s("R6", 2'd2, 3, 20'hCCCCC, DX);
    op_s("R6", 2'd2, 3, 20'hDDDDD, DX);
    op_s("R4", 2'd1, 3, 20'hCCCCC, DY);
    op_s("R4", 2'd1, 3, 20'hCCCCC, DX);
    op_s("R4", 2'd0, 3, 20'hCCCCC, DX);
    ctrl_s("R2", 8'h04);
    op_s("R2", 2'd0, 3, 20'hDDDDD, DX);
    ctrl_s("R2", 8'h01);
    op_s("R2", 2'd0, 3, 20'hDDDDD, DX);
    op_s("R6", 2'd2, 5, 20'h11111, DX);
    op_s("R6", 2'd2, 5, 20'h22222, DX);
    ctrl_s("R5", 8'h05);
    op_s("R5", 2'd0, 9, 20'h12345, DX);
    op_s("R5", 2'd0, 3, 20'h54321, DX);
    ctrl_s("R5", 8'h07);
    op_s("R5", 2'd0, 9, 20'h12345, DX);
    ctrl_s("R5", 8'h45);
    op_s("R5", 2'd0, 9, 20'h12345, DX);
    ctrl_s("R7", 8'h13);
    op_s("R7", 2'd2, 7, 20'h77777, DX);
    ctrl_s("R7", 8'h43);
    op_s("R7", 2'd0, 7, 20'h77777, DX);
    ctrl_s("R10", 8'hC3);
    op_s("R10", 2'd0, 3, 20'hCCCCC, DY);
    clr_s("R10", 2'b01);
    ctrl_s("R8", 8'h83);
    op_s("R8", 2'd2, 8, 20'h88888, DX);
    op_s("R8", 2'd0, 8, 20'h88888, DX);
    op_s("R8", 2'd0, 8, 20'h88888, DY);
    clr_s("R10", 2'b10);
    ctrl_s("R9", 8'hA3);
    op_s("R9", 2'd1, 8, 20'h88888, DY);
    ctrl_s("R9", 8'h83);
    op_s("R9", 2'd0, 8, 20'h88888, DX);
    op_s("R9", 2'd0, 8, 20'h88888, DY);
    clr_s("R10", 2'b11);

    for (int n = 0; n < 800; n++) begin
      bit cwe, swe;
      logic [7:0] cw;
      logic [DW-1:0] d;
      cwe = ($urandom_range(0, 9) == 0);
      swe = ($urandom_range(0, 7) == 0);
      cw = 8'($urandom);
      d = ($urandom_range(0, 1) == 0) ? DX : DY;
      step("R3", $urandom_range(0, 5) != 0, 2'($urandom), $urandom_range(0, 3),
           TW'($urandom_range(0, 4)), d, cwe, cw, swe, 2'($urandom));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule